// File: doc/BRIEF.md
# Light-Load Pulse-Skip Mode Controller

This block decides when a synchronous buck controller switches between continuous conduction and a light-load pulse-skip mode. At the end of every switching cycle it receives a one-clock strobe together with a flag telling whether the inductor current fell to zero during that cycle. It counts such cycles in an unbroken run. It enters pulse-skip mode only after a full run of crossings, and it leaves on the first cycle that ends without one. Because a single cycle of negative current restarts the run, the converter can still sink current after a negative load step.

While pulse-skip mode is active, the block does two things. It commands the low-side switch off whenever the live zero-current flag is raised. It also hands the on-time generator a stretched on-time of one and a half times the base value. A mode-enable input, decoded from the enable pin, keeps the block in continuous conduction when it is low. Dropping that input while the block is in pulse-skip mode leaves the mode on the next clock edge. All inputs are sampled on one system clock.

Top module: `lightload_skip_ctrl`

## Requirements
- R1: After reset, `skip_active` is 0, `ls_off_cmd` is 0 and `ton_eff` equals `ton_base`.
- R2: With `skip_en`=1, `skip_active` rises at the clock edge that samples the eighth consecutive strobe (`cyc_end`=1) carrying `zc_seen`=1. After only seven such strobes it stays 0.
- R3: A strobe with `zc_seen`=0 restarts the run, so a fresh eight crossing strobes are needed for entry.
- R4: While `skip_active`=1, a strobe with `zc_seen`=0 clears `skip_active` at that same edge.
- R5: While `skip_en`=0, `skip_active` never rises, however many crossing strobes arrive. Disabling also clears the run count.
- R6: Clearing `skip_en` while `skip_active`=1 clears `skip_active` at the next clock edge, with or without a strobe.
- R7: `ls_off_cmd` is 1 exactly when `skip_active`=1 and `zc_now`=1. Otherwise it is 0.
- R8: `ton_eff` is `ton_base` + floor(`ton_base`/2) while `skip_active`=1, and `ton_base` otherwise. It is one bit wider than `ton_base`, so the largest base does not overflow.
- R9: On clocks with `cyc_end`=0, the value of `zc_seen` is ignored and the mode does not change.
- R10: The run count saturates and does not wrap: a run of many more than eight crossing strobes keeps `skip_active` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| skip_en | input | 1 | Mode enable from the enable pin decoder (1 = pulse-skip allowed) |
| cyc_end | input | 1 | One-clock strobe at the end of each switching cycle |
| zc_seen | input | 1 | The inductor current reached zero in the cycle just ended |
| zc_now | input | 1 | Live zero-current flag from the comparator |
| ton_base | input | TW (12) | Base on-time from the on-time generator |
| skip_active | output | 1 | Pulse-skip mode is active |
| ls_off_cmd | output | 1 | Command to turn the low-side switch off |
| ton_eff | output | TW+1 (13) | On-time to use, stretched by 50% in pulse-skip mode |

## Verification
The embedded properties check, on every clock, these per-edge rules:
- a crossing-free strobe clears the run and leaves the mode;
- disabling empties the count and the mode one edge later;
- a clock without a strobe leaves the mode unchanged;
- every entry is preceded by a run that was one short of full;
- the switch-off command and the stretched on-time never appear outside the mode.

Only the bench scenarios show that entry takes exactly eight strobes and not seven, and that a broken run really needs eight fresh crossings. They also show that a long run does not wrap back out of the mode, and that the stretched on-time has the right value at odd and maximum bases.

// File: rtl/lls_pkg.sv
package lls_pkg;
  typedef enum logic {
    MODE_CCM  = 1'b0,
    MODE_SKIP = 1'b1
  } lls_mode_e;

  localparam int unsigned LLS_RUN_DEFAULT = 8;
  localparam int unsigned LLS_TON_DEFAULT = 12;
endpackage

// File: rtl/lls_run_count.sv
module lls_run_count #(
  parameter int unsigned RUN_LEN = 8,
  localparam int unsigned CW = $clog2(RUN_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          cyc_end,
  input  logic          zc_seen,
  output logic [CW-1:0] run,
  output logic          entry_hit
);
  localparam logic [CW-1:0] RUN_MAX  = CW'(RUN_LEN);
  localparam logic [CW-1:0] RUN_LAST = CW'(RUN_LEN - 1);

  logic xing_strobe;
  logic break_strobe;

  assign xing_strobe  = cyc_end & zc_seen;
  assign break_strobe = cyc_end & ~zc_seen;

  // the strobe that completes (or extends) a full run
  assign entry_hit = enable & xing_strobe & (run >= RUN_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= '0;
    end else if (!enable || break_strobe) begin
      run <= '0;
    end else if (xing_strobe && run != RUN_MAX) begin
      run <= run + 1'b1;
    end
  end

  // R3: a strobe without a crossing empties the run
  a_r3_break_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_end && !zc_seen) |=> (run == '0));

  // R5: disable empties the run
  a_r5_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable) |=> (run == '0));

  // R10: the count never passes its ceiling
  a_r10_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (run <= RUN_MAX));
endmodule

// File: rtl/lls_mode_fsm.sv
module lls_mode_fsm
  import lls_pkg::*;
#(
  parameter int unsigned RUN_LEN = 8,
  localparam int unsigned CW = $clog2(RUN_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          cyc_end,
  input  logic          zc_seen,
  input  logic          entry_hit,
  input  logic [CW-1:0] run,
  output logic          active
);
  lls_mode_e mode_q, mode_d;

  always_comb begin
    mode_d = mode_q;
    if (!enable)                 mode_d = MODE_CCM;
    else if (cyc_end && !zc_seen) mode_d = MODE_CCM;
    else if (entry_hit)           mode_d = MODE_SKIP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_CCM;
    else        mode_q <= mode_d;
  end

  assign active = (mode_q == MODE_SKIP);

  // R2: every entry follows a run one short of full plus a crossing strobe
  a_r2_entry_run: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> ($past(run) == CW'(RUN_LEN - 1) && $past(cyc_end) && $past(zc_seen)));

  // R4: a crossing-free strobe leaves the mode
  a_r4_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (active && cyc_end && !zc_seen) |=> !active);

  // R6: disable leaves the mode on the next edge
  a_r6_disable_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable) |=> !active);

  // R9: no strobe, no mode change
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !cyc_end) |=> $stable(active));
endmodule

// File: rtl/lls_out_drive.sv
module lls_out_drive #(
  parameter int unsigned TW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active,
  input  logic          zc_now,
  input  logic [TW-1:0] ton_base,
  output logic          ls_off_cmd,
  output logic [TW:0]   ton_eff
);
  function automatic logic [TW:0] stretch_half(input logic [TW-1:0] b);
    return {1'b0, b} + {2'b00, b[TW-1:1]};
  endfunction

  assign ls_off_cmd = active & zc_now;
  assign ton_eff    = active ? stretch_half(ton_base) : {1'b0, ton_base};

  // R7: no switch-off command outside the mode
  a_r7_off_only_in_skip: assert property (@(posedge clk) disable iff (!rst_n)
    (!active) |-> !ls_off_cmd);

  // R8: on-time is never stretched outside the mode, never shortened inside
  a_r8_no_stretch_ccm: assert property (@(posedge clk) disable iff (!rst_n)
    (!active) |-> (ton_eff == {1'b0, ton_base}));
  a_r8_stretch_not_short: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (ton_eff >= {1'b0, ton_base}));
endmodule

// File: rtl/lightload_skip_ctrl.sv
module lightload_skip_ctrl #(
  parameter int unsigned RUN_LEN = lls_pkg::LLS_RUN_DEFAULT,
  parameter int unsigned TW      = lls_pkg::LLS_TON_DEFAULT
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          skip_en,
  input  logic          cyc_end,
  input  logic          zc_seen,
  input  logic          zc_now,
  input  logic [TW-1:0] ton_base,
  output logic          skip_active,
  output logic          ls_off_cmd,
  output logic [TW:0]   ton_eff
);
  localparam int unsigned CW = $clog2(RUN_LEN + 1);

  logic [CW-1:0] run;
  logic          entry_hit;

  lls_run_count #(.RUN_LEN(RUN_LEN)) u_run (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (skip_en),
    .cyc_end   (cyc_end),
    .zc_seen   (zc_seen),
    .run       (run),
    .entry_hit (entry_hit)
  );

  lls_mode_fsm #(.RUN_LEN(RUN_LEN)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (skip_en),
    .cyc_end   (cyc_end),
    .zc_seen   (zc_seen),
    .entry_hit (entry_hit),
    .run       (run),
    .active    (skip_active)
  );

  lls_out_drive #(.TW(TW)) u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .active     (skip_active),
    .zc_now     (zc_now),
    .ton_base   (ton_base),
    .ls_off_cmd (ls_off_cmd),
    .ton_eff    (ton_eff)
  );
endmodule

// File: tb/sim_lightload_skip_ctrl.sv
module sim_lightload_skip_ctrl;
  localparam int TW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          skip_en = 1'b0;
  logic          cyc_end = 1'b0;
  logic          zc_seen = 1'b0;
  logic          zc_now = 1'b0;
  logic [TW-1:0] ton_base = 12'd200;
  logic          skip_active;
  logic          ls_off_cmd;
  logic [TW:0]   ton_eff;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  lightload_skip_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .skip_en(skip_en), .cyc_end(cyc_end),
    .zc_seen(zc_seen), .zc_now(zc_now), .ton_base(ton_base),
    .skip_active(skip_active), .ls_off_cmd(ls_off_cmd), .ton_eff(ton_eff)
  );

  // vector fields: {en, strobe, crossing, expected_active, repeat[4:0]}
  localparam int NV = 14;
  localparam logic [8:0] VEC [NV] = '{
    {4'b1110, 5'd7},   // R2 seven crossings: not yet
    {4'b1111, 5'd1},   // R2 eighth crossing enters
    {4'b1001, 5'd1},   // R9 no strobe, zc_seen=0 ignored
    {4'b1111, 5'd1},   // stays
    {4'b1100, 5'd1},   // R4 exit on first strobe without crossing
    {4'b1110, 5'd7},   // R3 rebuild
    {4'b1100, 5'd1},   // R3 break at seven
    {4'b1110, 5'd7},   // R3 fresh run of seven
    {4'b1111, 5'd1},   // R3 eighth fresh crossing enters
    {4'b0000, 5'd1},   // R6 disable exits next edge without strobe
    {4'b0110, 5'd10},  // R5 disabled: crossings ignored
    {4'b1110, 5'd7},   // R5 run was cleared by disable
    {4'b1111, 5'd20},  // R10 long run keeps mode
    {4'b1011, 5'd3}    // R9 idle clocks with zc_seen=1
  };

  function automatic int exp_ton(input int base, input bit act);
    return act ? (base * 3) / 2 : base;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input bit en, input bit ce, input bit zc);
    @(negedge clk);
    skip_en = en; cyc_end = ce; zc_seen = zc;
    @(posedge clk);
    #2;
    cyc_end = 1'b0;
  endtask

  initial begin
    #2_000_000;
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    chk("R1 active", int'(skip_active), 0);
    chk("R1 ls_off", int'(ls_off_cmd), 0);
    chk("R1 ton", int'(ton_eff), 200);
    @(negedge clk); rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      for (int r = 0; r < int'(VEC[v][4:0]); r++) begin
        step(VEC[v][8], VEC[v][7], VEC[v][6]);
        chk($sformatf("R2-table v%0d r%0d active", v, r), int'(skip_active), int'(VEC[v][5]));
        chk($sformatf("R8 v%0d ton", v), int'(ton_eff), exp_ton(200, VEC[v][5]));
      end
    end

    // R7: switch-off command follows live zero flag in mode
    zc_now = 1'b1; #1;
    chk("R7 in mode, zc_now=1", int'(ls_off_cmd), 1);
    zc_now = 1'b0; #1;
    chk("R7 in mode, zc_now=0", int'(ls_off_cmd), 0);

    // R8 at odd and maximum bases
    ton_base = 12'd301; #1;
    chk("R8 odd base", int'(ton_eff), 451);
    ton_base = 12'hFFF; #1;
    chk("R8 max base", int'(ton_eff), 6142);

    // R4 exit, then R7 and R8 in continuous conduction
    step(1, 1, 0);
    chk("R4 exit", int'(skip_active), 0);
    zc_now = 1'b1; #1;
    chk("R7 out of mode", int'(ls_off_cmd), 0);
    chk("R8 max base ccm", int'(ton_eff), 4095);
    zc_now = 1'b0;

    // R1 reset from inside the mode
    for (int i = 0; i < 8; i++) step(1, 1, 1);
    chk("R2 re-entry", int'(skip_active), 1);
    @(negedge clk); rst_n = 1'b0; #1;
    chk("R1 reset clears mode", int'(skip_active), 0);
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < 7; i++) step(1, 1, 1);
    chk("R1 run cleared by reset", int'(skip_active), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule